// File: doc/BRIEF.md
# Tagged Sample Queue with Byte Readout

This block sits between an analog-to-digital converter and a host bus. Every completed conversion delivers a 12-bit offset-binary result (0 is negative full scale, 4095 is positive full scale) and the 4-bit number of the channel it came from. The block pushes the pair into a first-in first-out store without host involvement. It does this in every operating mode.

The host reads the oldest entry through two byte-wide views or one 16-bit view. One byte carries the low result nibble and the channel tag. The other carries the upper eight result bits. In byte mode the host reads the low byte first and then the high byte; reading the high byte retires the entry. In word mode a single read of the low address returns both bytes and retires the entry.

A sticky overrun flag records any sample that arrived while the store was full; that sample is discarded. A half-full flag drives interrupt generation. A write to the channel scan-limit register empties the store and resets the overrun flag.

Top module: `sample_queue`

## Requirements
- R1: Each cycle with `sampleValid` high and no clear stores one entry, and entries are read back in arrival order.
- R2: The store holds `DEPTH` (default 1024) entries. `full` is high exactly when it holds `DEPTH` entries, and `empty` is high exactly when it holds none.
- R3: `loByte` bits 7..4 carry result bits 3..0 of the oldest entry, and `loByte` bits 3..0 carry its channel number.
- R4: `hiByte` carries result bits 11..4 of the oldest entry, with result bit 11 in bit 7.
- R5: `wordOut` equals `hiByte` in bits 15..8 concatenated with `loByte` in bits 7..0.
- R6: With `wideMode` low, a `rdHiStb` pulse retires the oldest entry. A `rdLoStb` pulse alone retires nothing.
- R7: With `wideMode` high, a `rdLoStb` pulse retires the oldest entry. `rdHiStb` retires nothing.
- R8: A sample that arrives while the store is full and nothing is retired in that cycle is dropped and sets `overrun`. `overrun` stays high until a clear.
- R9: A `scanLimitWr` pulse empties the store and clears `overrun` by the next cycle. A sample arriving in the same cycle is discarded.
- R10: `halfFull` is high when the store holds `DEPTH/2` (512) or more entries.
- R11: After reset the store is empty and `overrun` is low. While the store is empty, `loByte` and `hiByte` read 0.
- R12: A retire request while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A conversion result is present this cycle |
| sampleData | input | 12 | Offset-binary conversion result |
| sampleChan | input | 4 | Channel that produced the result |
| scanLimitWr | input | 1 | Scan-limit register write; empties the store |
| wideMode | input | 1 | 1 = 16-bit reads, 0 = byte reads |
| rdLoStb | input | 1 | Host read of the low address |
| rdHiStb | input | 1 | Host read of the high address |
| loByte | output | 8 | Low result nibble and channel tag |
| hiByte | output | 8 | Upper eight result bits |
| wordOut | output | 16 | High byte over low byte |
| halfFull | output | 1 | Occupancy at or above half depth |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | No entries held |
| overrun | output | 1 | Sticky flag for a dropped sample |

## Verification
The bench fills the store to exactly 1024 entries and pushes one more sample. A design with an off-by-one depth would either take that extra sample or flag overrun one sample early. Draining the store then exposes an overwrite: the head entry would have been replaced by the dropped sample.

The half-full edge is checked at 511 and at 512 entries. The bench reads the low byte alone in byte mode, where a design that retires on that read would skip entries. It sends a clear and a sample in the same cycle, where a design that lets the push win would end up non-empty. It also retires from an empty store, where a design would wrap its pointers and show stale data.

// File: rtl/sample_queue_pkg.sv
package sample_queue_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } qStrobes_t;

  function automatic logic [15:0] packEntry(input logic [11:0] data, input logic [3:0] chan);
    return {data, chan};
  endfunction
endpackage

// File: rtl/sample_queue_ctrl.sv
module sample_queue_ctrl
  import sample_queue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  input  logic      scanLimitWr,
  input  logic      wideMode,
  input  logic      rdLoStb,
  input  logic      rdHiStb,
  input  logic      full,
  input  logic      empty,
  output qStrobes_t strobes,
  output logic      overrun
);
  logic retireReq;
  logic dropNow;

  always_comb begin
    retireReq     = wideMode ? rdLoStb : rdHiStb;
    strobes.clear = scanLimitWr;
    strobes.pop   = !scanLimitWr && !empty && retireReq;
    strobes.push  = sampleValid && !scanLimitWr && (!full || strobes.pop);
    dropNow       = sampleValid && !scanLimitWr && full && !strobes.pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overrun <= 1'b0;
    else if (scanLimitWr) overrun <= 1'b0;
    else if (dropNow)     overrun <= 1'b1;
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !scanLimitWr) |=> overrun);
  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!overrun && !(sampleValid && full)) |=> !overrun);
  // R12
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strobes.pop);
endmodule

// File: rtl/sample_queue_dp.sv
module sample_queue_dp
  import sample_queue_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  qStrobes_t   strobes,
  input  logic [11:0] sampleData,
  input  logic [3:0]  sampleChan,
  output logic [7:0]  loByte,
  output logic [7:0]  hiByte,
  output logic        full,
  output logic        empty,
  output logic        halfFull
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [15:0]      store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] level;
  logic [15:0]      headEntry;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= packEntry(sampleData, sampleChan);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strobes.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobes.push) wrPtr <= bump(wrPtr);
      if (strobes.pop)  rdPtr <= bump(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_comb begin
    full      = (level == FULL_CNT);
    empty     = (level == '0);
    halfFull  = (level >= HALF_CNT);
    headEntry = empty ? 16'h0000 : store[rdPtr];
    hiByte    = headEntry[15:8];
    loByte    = headEntry[7:0];
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_CNT);
  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> empty);
  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
endmodule

// File: rtl/sample_queue.sv
module sample_queue
  import sample_queue_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [11:0] sampleData,
  input  logic [3:0]  sampleChan,
  input  logic        scanLimitWr,
  input  logic        wideMode,
  input  logic        rdLoStb,
  input  logic        rdHiStb,
  output logic [7:0]  loByte,
  output logic [7:0]  hiByte,
  output logic [15:0] wordOut,
  output logic        halfFull,
  output logic        full,
  output logic        empty,
  output logic        overrun
);
  qStrobes_t strobes;

  sample_queue_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .scanLimitWr(scanLimitWr),
    .wideMode(wideMode), .rdLoStb(rdLoStb), .rdHiStb(rdHiStb),
    .full(full), .empty(empty), .strobes(strobes), .overrun(overrun)
  );

  sample_queue_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleData(sampleData),
    .sampleChan(sampleChan), .loByte(loByte), .hiByte(hiByte),
    .full(full), .empty(empty), .halfFull(halfFull)
  );

  assign wordOut = {hiByte, loByte};
endmodule

// File: tb/tb_sample_queue.sv
module tb_sample_queue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic [3:0]  sampleChan = '0;
  logic        scanLimitWr = 1'b0;
  logic        wideMode = 1'b0;
  logic        rdLoStb = 1'b0;
  logic        rdHiStb = 1'b0;
  logic [7:0]  loByte, hiByte;
  logic [15:0] wordOut;
  logic        halfFull, full, empty, overrun;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sample_queue dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge; the state changes at the next posedge; settle to the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sampleValid = 0; scanLimitWr = 0; rdLoStb = 0; rdHiStb = 0;
    #0.5;
  endtask

  task automatic push(input logic [11:0] d, input logic [3:0] c);
    sampleValid = 1; sampleData = d; sampleChan = c;
    step();
  endtask

  task automatic testReset();
    chk("R11 empty", 16'(empty), 16'd1);
    chk("R11 overrun", 16'(overrun), 16'd0);
    chk("R11 word", wordOut, 16'h0000);
  endtask

  task automatic testByteOrder();
    wideMode = 0;
    push(12'hA5C, 4'h3);
    push(12'h123, 4'hE);
    chk("R3 lo byte", 16'(loByte), 16'h0C3);
    chk("R4 hi byte", 16'(hiByte), 16'h0A5);
    rdLoStb = 1; step();
    chk("R6 lo read keeps head", 16'(loByte), 16'h0C3);
    rdHiStb = 1; step();
    chk("R1 second entry lo", 16'(loByte), 16'h03E);
    chk("R1 second entry hi", 16'(hiByte), 16'h012);
    rdHiStb = 1; step();
    chk("R6 drained", 16'(empty), 16'd1);
  endtask

  task automatic testWide();
    wideMode = 1;
    push(12'hFFF, 4'hF);
    push(12'h000, 4'h0);
    chk("R5 word", wordOut, 16'hFFFF);
    rdHiStb = 1; step();
    chk("R7 hi read no pop", wordOut, 16'hFFFF);
    rdLoStb = 1; step();
    chk("R7 pop gives next", wordOut, 16'h0000);
    chk("R7 not empty", 16'(empty), 16'd0);
    rdLoStb = 1; step();
    chk("R7 empty", 16'(empty), 16'd1);
  endtask

  task automatic testPopEmpty();
    wideMode = 1;
    rdLoStb = 1; step();
    rdLoStb = 1; step();
    push(12'h456, 4'h7);
    chk("R12 data after empty pop", wordOut, 16'h4567);
    rdLoStb = 1; step();
    chk("R12 empty again", 16'(empty), 16'd1);
  endtask

  task automatic testFillOverrun();
    int bad;
    wideMode = 1;
    for (int i = 0; i < 1024; i++) begin
      if (i == 511) chk("R10 below half", 16'(halfFull), 16'd0);
      if (i == 512) chk("R10 at half", 16'(halfFull), 16'd1);
      push(12'(i * 7), 4'(i));
      if (i == 1022) chk("R2 not yet full", 16'(full), 16'd0);
    end
    chk("R2 full", 16'(full), 16'd1);
    chk("R8 no overrun at depth", 16'(overrun), 16'd0);
    push(12'hABC, 4'hD);
    chk("R8 overrun set", 16'(overrun), 16'd1);
    chk("R8 head kept", wordOut, {12'd0, 4'd0});
    bad = 0;
    for (int i = 0; i < 1024; i++) begin
      if (wordOut !== {12'(i * 7), 4'(i)}) bad++;
      rdLoStb = 1; step();
    end
    chk("R1 drain order, dropped sample absent", 16'(bad), 16'd0);
    chk("R2 empty after drain", 16'(empty), 16'd1);
    chk("R8 sticky", 16'(overrun), 16'd1);
  endtask

  task automatic testClear();
    push(12'h321, 4'h1);
    push(12'h654, 4'h2);
    scanLimitWr = 1; sampleValid = 1; sampleData = 12'h777; sampleChan = 4'h7;
    step();
    chk("R9 empty", 16'(empty), 16'd1);
    chk("R9 overrun cleared", 16'(overrun), 16'd0);
    chk("R9 push discarded", wordOut, 16'h0000);
    push(12'h89A, 4'hB);
    chk("R9 usable after clear", wordOut, 16'h89AB);
  endtask

  initial begin
    fork
      begin
        #10 rstN = 1;
        @(negedge clk); #0.5;
        testReset();
        testByteOrder();
        testWide();
        testPopEmpty();
        testFillOverrun();
        testClear();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule